// File: doc/BRIEF.md
# Unsigned Array Multiplier

This block multiplies two unsigned operands of equal width and returns their full double-width product. It contains no clock and no state. The product settles after the carries have travelled through the adder grid. With the default width of 4 bits, it takes two 4-bit magnitudes and produces an 8-bit result. It can also serve as the magnitude datapath of a sign-and-magnitude multiply.

The grid is built from one kind of cell. Each cell ANDs one multiplicand bit with one multiplier bit. It then adds that partial product to a sum arriving from the cell above and a carry from its lower-order neighbour in the same row.

- The first row has no adders. It only forms the partial products of multiplier bit 0.
- Every later row is a ripple-carry chain of cells. The carry-in of each row's first cell is tied to 0.
- For width 4 this gives 16 AND gates and 12 adders. Four of those adders act as half adders: the three carry-in-zero cells, plus the top cell of the first adder row, whose input from above is 0.
- The multiplicand is spread along the cell diagonals and the multiplier along the rows. No `*` operator is used in the datapath.

Top module: `amul_array`

## Requirements
- R1: For every pair of unsigned operands, `p_o` equals the arithmetic product of `a_i` and `b_i` over the full 8 bits (no truncation).
- R2: Product bit 0 equals `a_i[0] & b_i[0]`.
- R3: Product bit 1 equals `(a_i[1] & b_i[0]) ^ (a_i[0] & b_i[1])`.
- R4: If either operand is 0, `p_o` is 8'h00.
- R5: The largest operands, 15 times 15, give 8'hE1.
- R6: Product bit 7, the final carry-out of the last adder row, is 1 exactly when the product is 128 or more.
- R7: The block is purely combinational. `p_o` follows a change on `a_i` or `b_i` with no clock edge in between.
- R8: If one operand is 1, `p_o` equals the other operand, zero-extended.
- R9: If `b_i` is a power of two, 2^k, then `p_o` equals `a_i` shifted left by k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Multiplicand, unsigned |
| b_i | input | 4 | Multiplier, unsigned |
| p_o | output | 8 | Product, unsigned |

## Verification
The main function is first tried with a short table of hand-computed pairs. Some of these have sparse bit patterns and some have dense ones. Sparse pairs expose a wrong partial-product wire. Dense pairs such as 15 times 15 drive every carry chain in full and expose a dropped or misrouted carry.

An exhaustive sweep over all 256 pairs follows. It catches any single miswired cell, because every cell changes the result for some pair.

Directed patterns complete the set:
- Zero operands show that no stray carry is ever created.
- Unit operands show that each row passes its sum straight through.
- Power-of-two multipliers single out one row at a time, so a fault can be traced to the row that owns it.
- The top-bit threshold at 128 separates the final carry from the sum bits.

// File: rtl/amul_pkg.sv
package amul_pkg;

    // Default operand width of the array multiplier
    localparam int unsigned AMUL_WIDTH = 4;

    // Result of one adder cell
    typedef struct packed {
        logic carry;
        logic sum;
    } cell_res_t;

endpackage

// File: rtl/amul_cell.sv
module amul_cell
    import amul_pkg::*;
(
    input  logic mcand_i,
    input  logic mplier_i,
    input  logic sum_i,
    input  logic carry_i,
    output logic sum_o,
    output logic carry_o
);

    logic      pp;
    cell_res_t res_d;

    // One AND gate forms the local partial product.
    always_comb begin
        pp = mcand_i & mplier_i;
    end

    // Full adder built from gates; tying carry_i low gives a half adder.
    always_comb begin
        res_d.sum   = pp ^ sum_i ^ carry_i;
        res_d.carry = (pp & sum_i) | (pp & carry_i) | (sum_i & carry_i);
    end

    assign sum_o   = res_d.sum;
    assign carry_o = res_d.carry;

    // R1: the two cell outputs weigh the same as the three ones added in
    always_comb begin
        p_cell_weight_r1: assert ({carry_o, sum_o} ==
                                  (2'(pp) + 2'(sum_i) + 2'(carry_i)))
            else $error("cell weight mismatch");
    end

endmodule

// File: rtl/amul_row.sv
module amul_row #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] mcand_i,
    input  logic             mplier_i,
    input  logic [WIDTH-1:0] above_i,
    output logic [WIDTH:0]   row_o
);

    localparam int unsigned RW = WIDTH + 1;

    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] sums;

    // The first cell of the row has its carry-in tied low.
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        amul_cell i_cell (
            .mcand_i (mcand_i[i]),
            .mplier_i(mplier_i),
            .sum_i   (above_i[i]),
            .carry_i (chain[i]),
            .sum_o   (sums[i]),
            .carry_o (chain[i+1])
        );
    end

    assign row_o = {chain[WIDTH], sums};

    // R1: a row adds its gated multiplicand to the sum arriving from above
    always_comb begin
        p_row_add_r1: assert (row_o == (RW'(above_i) +
                                        RW'(mcand_i & {WIDTH{mplier_i}})))
            else $error("row sum mismatch");
    end

endmodule

// File: rtl/amul_array.sv
module amul_array
    import amul_pkg::*;
#(
    parameter int unsigned WIDTH = AMUL_WIDTH
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [2*WIDTH-1:0] p_o
);

    localparam int unsigned PW = 2 * WIDTH;

    // stage[j] holds the running sum after multiplier bit j; bit 0 retires
    logic [WIDTH:0] stage [WIDTH];

    // Top row: AND gates only, no adders.
    for (genvar i = 0; i < WIDTH; i++) begin : g_top
        assign stage[0][i] = a_i[i] & b_i[0];
    end
    assign stage[0][WIDTH] = 1'b0;

    // Adder rows, one for each remaining multiplier bit.
    for (genvar j = 1; j < WIDTH; j++) begin : g_row
        amul_row #(.WIDTH(WIDTH)) i_row (
            .mcand_i (a_i),
            .mplier_i(b_i[j]),
            .above_i (stage[j-1][WIDTH:1]),
            .row_o   (stage[j])
        );
    end

    // Low product bits retire one per row; high bits come from the last row.
    for (genvar j = 0; j < WIDTH; j++) begin : g_low
        assign p_o[j] = stage[j][0];
    end
    assign p_o[PW-1:WIDTH] = stage[WIDTH-1][WIDTH:1];

    // R1: whole product; R2: bit 0; R3: bit 1; R6: top bit marks the upper half
    always_comb begin
        p_product_r1: assert (p_o == (PW'(a_i) * PW'(b_i)))
            else $error("product mismatch");
        p_bit0_r2: assert (p_o[0] == (a_i[0] & b_i[0]))
            else $error("bit 0 mismatch");
        p_bit1_r3: assert (p_o[1] == ((a_i[1] & b_i[0]) ^ (a_i[0] & b_i[1])))
            else $error("bit 1 mismatch");
        p_top_bit_r6: assert (p_o[PW-1] ==
                              ((PW'(a_i) * PW'(b_i)) >= (PW'(1) << (PW-1))))
            else $error("top bit mismatch");
    end

endmodule

// File: tb/test_amul_array.sv
module test_amul_array;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned W          = 4;
    localparam int unsigned WATCHDOG   = 20000;
    localparam int unsigned NVEC       = 12;

    // Each entry: {a, b, expected product}
    localparam logic [15:0] VECS [NVEC] = '{
        {4'd3,  4'd11, 8'h21},
        {4'd13, 4'd11, 8'h8F},
        {4'd15, 4'd15, 8'hE1},
        {4'd7,  4'd9,  8'h3F},
        {4'd10, 4'd5,  8'h32},
        {4'd0,  4'd15, 8'h00},
        {4'd15, 4'd0,  8'h00},
        {4'd1,  4'd13, 8'h0D},
        {4'd8,  4'd8,  8'h40},
        {4'd12, 4'd12, 8'h90},
        {4'd9,  4'd14, 8'h7E},
        {4'd6,  4'd6,  8'h24}
    };

    logic         clk = 1'b0;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [7:0]   p;
    int           n_checks = 0;
    int           n_fail   = 0;
    int           cycles   = 0;
    logic         done     = 1'b0;

    amul_array #(.WIDTH(W)) i_amul_array (
        .a_i(a),
        .b_i(b),
        .p_o(p)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d actual=%0h expected=%0h",
                     req, a, b, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv);
        a = av;
        b = bv;
        #1;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles >= WATCHDOG) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // Initial state, both operands zero (R4)
        drive(4'd0, 4'd0);
        check("R4", p, 8'h00);

        // Table of hand-computed pairs (R1)
        for (int k = 0; k < NVEC; k++) begin
            drive(VECS[k][15:12], VECS[k][11:8]);
            check("R1", p, VECS[k][7:0]);
        end

        // Exhaustive sweep (R1, R2, R3, R6)
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                logic [7:0] e;
                e = 8'(x) * 8'(y);
                drive(4'(x), 4'(y));
                check("R1", p, e);
                check("R2", {7'd0, p[0]}, {7'd0, a[0] & b[0]});
                check("R3", {7'd0, p[1]},
                      {7'd0, (a[1] & b[0]) ^ (a[0] & b[1])});
                check("R6", {7'd0, p[7]}, {7'd0, e >= 8'd128});
            end
        end

        // Zero on either side (R4)
        for (int x = 0; x < 16; x++) begin
            drive(4'(x), 4'd0);
            check("R4", p, 8'h00);
            drive(4'd0, 4'(x));
            check("R4", p, 8'h00);
        end

        // Largest operands (R5)
        drive(4'd15, 4'd15);
        check("R5", p, 8'hE1);

        // Top-bit threshold around 128 (R6)
        drive(4'd8, 4'd15);
        check("R6", p, 8'h78);
        drive(4'd8, 4'd16 - 4'd0 - 4'd0);
        drive(4'd11, 4'd12);
        check("R6", {7'd0, p[7]}, 8'h01);
        drive(4'd9, 4'd14);
        check("R6", {7'd0, p[7]}, 8'h00);

        // Combinational response without any clock edge (R7)
        @(negedge clk);
        drive(4'd5, 4'd3);
        check("R7", p, 8'h0F);
        drive(4'd14, 4'd3);
        check("R7", p, 8'h2A);

        // Identity operand (R8)
        for (int x = 0; x < 16; x++) begin
            drive(4'd1, 4'(x));
            check("R8", p, 8'(x));
            drive(4'(x), 4'd1);
            check("R8", p, 8'(x));
        end

        // Power-of-two multiplier selects one row (R9)
        for (int k = 0; k < 4; k++) begin
            for (int x = 0; x < 16; x++) begin
                drive(4'(x), 4'(1 << k));
                check("R9", p, 8'(x) << k);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule